// File: doc/BRIEF.md
# Multi-lane elastic release buffer

The block takes in words from several serial lanes whose skew differs from lane to lane and from one power-up to the next. A lane first shows alignment words. When the first data word after them arrives, the lane starts writing into its own small elastic store. Each lane fills at its own pace, so early lanes hold more words than late ones.

A single read pointer, shared by every lane, starts on a release event. The release event comes from the multiframe boundary pulse. The first pulse seen after every lane has begun buffering starts a delay of a programmable number of link clocks, and the release fires when that delay ends. From then on one word per lane leaves every cycle, with all lanes in step. This gives the same latency from one power-up to the next.

If a lane fills its store and another word arrives before reads have started, the buffer cannot absorb the skew. The block then raises a deskew error that stays set. This happens for example when the offset places the release far from the arrival times. A restart pulse clears all lane state, the release and the error so that a fresh alignment sequence can begin.

Top module: `elastic_release_buf`

## Requirements
- R1: After reset, `rel_vld` is 0, `dskw_err` is 0 and `rel_dat` is all zeros.
- R2: A lane ignores data words (`ln_vld`=1, `ln_algn`=0) until it has seen at least one alignment word (`ln_vld`=1, `ln_algn`=1). The first data word after that alignment is stored as entry 0, and it is the first word that lane presents after release.
- R3: With `rel_ofs`=0, if `mf_tick` is high in cycle T, and every lane wrote its first data word in some cycle before T, the release happens in cycle T and `rel_vld` reads 1 from cycle T+1.
- R4: With `rel_ofs`=k>0, a qualifying `mf_tick` in cycle T moves the release to cycle T+k, so `rel_vld` reads 1 from cycle T+k+1.
- R5: `rel_dat` is made of lane slices, each `DATA_W` bits wide, with lane i at bits [i*DATA_W +: DATA_W]. From cycle R+1 on, where R is the release cycle, the slice of every lane holds that lane's word number (c-R-1) in cycle c. `rel_vld` stays 1.
- R6: `mf_tick` pulses that come while some lane has not yet written its first data word are ignored, and so are pulses after the release.
- R7: Each lane store holds `DEPTH` (8) words. If a lane holds 8 words and writes again in a cycle with no read, `dskw_err` reads 1 from the next cycle. With no gaps in the data this happens exactly when the release cycle is 8 or more cycles after the earliest lane's first data cycle. A gap of 7 gives no error.
- R8: `dskw_err` stays at 1 until a reset or a `restart` pulse.
- R9: Before the release `rel_vld` is 0 and `rel_dat` is all zeros.
- R10: A `restart` pulse in cycle c clears the release, the error and the state of every lane, so that `rel_vld`=0 and `dskw_err`=0 from cycle c+1. A new alignment sequence then works as it does after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst_n | input | 1 | Asynchronous active-low reset, released on a clock edge inside the block |
| restart | input | 1 | Starts a new alignment sequence: clears lanes, release and error |
| mf_tick | input | 1 | Multiframe boundary pulse, one cycle wide |
| rel_ofs | input | OFS_W | Delay from the boundary pulse to the release, in link clocks |
| ln_vld | input | NUM_LANES | Word present on a lane this cycle |
| ln_algn | input | NUM_LANES | The word on a lane is an alignment word |
| ln_dat | input | NUM_LANES*DATA_W | Lane words, lane i at [i*DATA_W +: DATA_W] |
| rel_vld | output | 1 | Released data is valid, the same for all lanes |
| rel_dat | output | NUM_LANES*DATA_W | Released words, same slicing as `ln_dat` |
| dskw_err | output | 1 | Sticky lane deskew error |

## Verification
Each result has a fixed arrival cycle. The release registers on the edge that ends the release cycle, so `rel_vld` and the first word are due one cycle after the release. The release itself is due in the tick cycle plus `rel_ofs`. An overflow write in cycle S+8, with S the earliest lane's first data cycle, shows on `dskw_err` in cycle S+9. A restart shows one cycle later. The bench drives inputs and samples outputs on the falling edge. For every cycle of a scenario it works out from these counts which values are due, and compares them, so an answer that comes one cycle early or late is reported.

// File: rtl/erb_pkg.sv
package erb_pkg;

  typedef enum logic [1:0] {
    LN_IDLE  = 2'd0,
    LN_ALIGN = 2'd1,
    LN_FILL  = 2'd2
  } ln_state_e;

endpackage

// File: rtl/erb_lane.sv
module erb_lane
  import erb_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              in_vld,
  input  logic              in_algn,
  input  logic [DATA_W-1:0] in_dat,
  input  logic              rd_en,
  input  logic [AW-1:0]     rd_ptr,
  output logic              filling,
  output logic              ovf,
  output logic [DATA_W-1:0] rd_dat
);

  ln_state_e             st_q, st_d;
  logic [AW-1:0]         wptr_q, wptr_d;
  logic [CW-1:0]         occ_q, occ_d;
  logic                  wr_req, wr_ok, rd_eff, full;
  logic [DEPTH-1:0][DATA_W-1:0] mem_q;

  assign full = (occ_q == CW'(DEPTH));

  always_comb begin
    st_d   = st_q;
    wr_req = 1'b0;
    unique case (st_q)
      LN_IDLE: begin
        if (in_vld && in_algn) st_d = LN_ALIGN;
      end
      LN_ALIGN: begin
        if (in_vld && !in_algn) begin
          st_d   = LN_FILL;
          wr_req = 1'b1;
        end
      end
      LN_FILL: begin
        wr_req = in_vld;
      end
      default: st_d = LN_IDLE;
    endcase
    if (clr) begin
      st_d   = LN_IDLE;
      wr_req = 1'b0;
    end
  end

  always_comb begin
    rd_eff = rd_en && !clr && ((occ_q != '0) || wr_req);
    ovf    = wr_req && full && !rd_eff;
    wr_ok  = wr_req && !ovf;
    wptr_d = wptr_q;
    if (wr_ok) wptr_d = (wptr_q == AW'(DEPTH - 1)) ? '0 : wptr_q + AW'(1);
    occ_d  = occ_q + CW'(wr_ok) - CW'(rd_eff);
    if (clr) begin
      wptr_d = '0;
      occ_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= LN_IDLE;
      wptr_q <= '0;
      occ_q  <= '0;
    end else begin
      st_q   <= st_d;
      wptr_q <= wptr_d;
      occ_q  <= occ_d;
    end
  end

  // storage: no reset, write enable only
  always_ff @(posedge clk) begin
    if (wr_ok) mem_q[wptr_q] <= in_dat;
  end

  assign rd_dat  = mem_q[rd_ptr];
  assign filling = (st_q == LN_FILL);

  p_occ_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    occ_q <= CW'(DEPTH));

  p_fill_after_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_q == LN_FILL) |-> $past(st_q == LN_ALIGN));

  p_restart_empties_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (occ_q == '0) && (st_q == LN_IDLE));

endmodule

// File: rtl/erb_release.sv
module erb_release #(
  parameter int DEPTH = 8,
  parameter int OFS_W = 5,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             armed,
  input  logic             tick,
  input  logic [OFS_W-1:0] ofs,
  output logic             released,
  output logic             rd_en,
  output logic [AW-1:0]    rd_ptr
);

  logic             rel_q, rel_d;
  logic             pend_q, pend_d;
  logic [OFS_W-1:0] cnt_q, cnt_d;
  logic [AW-1:0]    rptr_q, rptr_d;
  logic             fire;

  always_comb begin
    fire   = 1'b0;
    pend_d = pend_q;
    cnt_d  = cnt_q;
    if (!rel_q) begin
      if (pend_q) begin
        if (cnt_q == '0) begin
          fire   = 1'b1;
          pend_d = 1'b0;
        end else begin
          cnt_d = cnt_q - OFS_W'(1);
        end
      end else if (armed && tick) begin
        if (ofs == '0) begin
          fire = 1'b1;
        end else begin
          pend_d = 1'b1;
          cnt_d  = ofs - OFS_W'(1);
        end
      end
    end
    rel_d  = rel_q || fire;
    rptr_d = '0;
    if (rel_q) rptr_d = (rptr_q == AW'(DEPTH - 1)) ? '0 : rptr_q + AW'(1);
    if (clr) begin
      rel_d  = 1'b0;
      pend_d = 1'b0;
      cnt_d  = '0;
      rptr_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rel_q  <= 1'b0;
      pend_q <= 1'b0;
      cnt_q  <= '0;
      rptr_q <= '0;
    end else begin
      rel_q  <= rel_d;
      pend_q <= pend_d;
      cnt_q  <= cnt_d;
      rptr_q <= rptr_d;
    end
  end

  assign released = rel_q;
  assign rd_en    = rel_q;
  assign rd_ptr   = rptr_q;

  p_rel_needs_arm_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rel_q) |-> $past(armed));

  p_ofs0_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!rel_q && !pend_q && armed && tick && (ofs == '0) && !clr) |=> rel_q);

  p_rptr_steps_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_q && !clr) |=> (rptr_q == (($past(rptr_q) == AW'(DEPTH - 1)) ? '0 : $past(rptr_q) + AW'(1))));

  p_pend_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && (cnt_q != '0) && !clr) |=> !rel_q && pend_q);

endmodule

// File: rtl/elastic_release_buf.sv
module elastic_release_buf
  import erb_pkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter int DATA_W    = 32,
  parameter int DEPTH     = 8,
  parameter int OFS_W     = 5,
  localparam int AW       = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int BUS_W    = NUM_LANES * DATA_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 restart,
  input  logic                 mf_tick,
  input  logic [OFS_W-1:0]     rel_ofs,
  input  logic [NUM_LANES-1:0] ln_vld,
  input  logic [NUM_LANES-1:0] ln_algn,
  input  logic [BUS_W-1:0]     ln_dat,
  output logic                 rel_vld,
  output logic [BUS_W-1:0]     rel_dat,
  output logic                 dskw_err
);

  // reset: asynchronous assert, release aligned to clk
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [NUM_LANES-1:0] filling, ovf;
  logic [BUS_W-1:0]     rd_bus;
  logic                 released, rd_en, all_fill;
  logic [AW-1:0]        rd_ptr;
  logic                 err_q, err_d;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    erb_lane #(
      .DATA_W (DATA_W),
      .DEPTH  (DEPTH)
    ) u_lane (
      .clk     (clk),
      .rst_n   (rst_int_n),
      .clr     (restart),
      .in_vld  (ln_vld[g]),
      .in_algn (ln_algn[g]),
      .in_dat  (ln_dat[g*DATA_W +: DATA_W]),
      .rd_en   (rd_en),
      .rd_ptr  (rd_ptr),
      .filling (filling[g]),
      .ovf     (ovf[g]),
      .rd_dat  (rd_bus[g*DATA_W +: DATA_W])
    );
  end

  assign all_fill = &filling;

  erb_release #(
    .DEPTH (DEPTH),
    .OFS_W (OFS_W)
  ) u_rel (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .clr      (restart),
    .armed    (all_fill),
    .tick     (mf_tick),
    .ofs      (rel_ofs),
    .released (released),
    .rd_en    (rd_en),
    .rd_ptr   (rd_ptr)
  );

  always_comb begin
    err_d = err_q || (|ovf);
    if (restart) err_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) err_q <= 1'b0;
    else            err_q <= err_d;
  end

  assign rel_vld  = released;
  assign rel_dat  = released ? rd_bus : '0;
  assign dskw_err = err_q;

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (err_q && !restart) |=> err_q);

  p_vld_needs_lanes_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    rel_vld |-> all_fill);

  p_restart_clears_r10: assert property (@(posedge clk) disable iff (!rst_int_n)
    restart |=> !rel_vld && !dskw_err);

endmodule

// File: tb/sim_elastic_release_buf.sv
module sim_elastic_release_buf;

  localparam int NL    = 4;
  localparam int DW    = 32;
  localparam int OFS_W = 5;
  localparam int MF    = 16;
  localparam int NALGN = 4;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              restart;
  logic              mf_tick;
  logic [OFS_W-1:0]  rel_ofs;
  logic [NL-1:0]     ln_vld, ln_algn;
  logic [NL*DW-1:0]  ln_dat;
  logic              rel_vld;
  logic [NL*DW-1:0]  rel_dat;
  logic              dskw_err;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  elastic_release_buf #(
    .NUM_LANES (NL),
    .DATA_W    (DW),
    .DEPTH     (8),
    .OFS_W     (OFS_W)
  ) u0 (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (restart),
    .mf_tick  (mf_tick),
    .rel_ofs  (rel_ofs),
    .ln_vld   (ln_vld),
    .ln_algn  (ln_algn),
    .ln_dat   (ln_dat),
    .rel_vld  (rel_vld),
    .rel_dat  (rel_dat),
    .dskw_err (dskw_err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s cyc=%0d act=%h exp=%h", tag, cyc, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_bad++;
      $display("FAIL watchdog cyc=%0d act=running exp=done", cyc);
      finish_run();
    end
  end

  // st: first data cycle per lane; j0: junk words ahead of lane 0 alignment
  task automatic run_scn(input int s0, input int s1, input int s2, input int s3,
                         input int j0, input int ofs, input int tph,
                         input int ncyc, input string vtag);
    int st[NL];
    int mx, mn, tk, trel, errc;
    bit experr;
    st[0] = s0; st[1] = s1; st[2] = s2; st[3] = s3;
    mx = st[0]; mn = st[0];
    for (int l = 1; l < NL; l++) begin
      if (st[l] > mx) mx = st[l];
      if (st[l] < mn) mn = st[l];
    end
    tk = mx + 1;
    while (!(tk >= tph && ((tk - tph) % MF) == 0)) tk++;
    trel   = tk + ofs;
    experr = (trel - mn) >= 8;
    errc   = mn + 9;
    for (int c = 0; c < ncyc; c++) begin
      @(negedge clk);
      if (c >= 1) begin
        bit ev, ee;
        ev = (c >= trel + 1);
        ee = experr && (c >= errc);
        chk((c == 1) ? "R10" : vtag, {31'd0, rel_vld}, {31'd0, ev});
        chk((c == 1) ? "R10" : (ee ? "R8" : "R7"), {31'd0, dskw_err}, {31'd0, ee});
        for (int l = 0; l < NL; l++) begin
          if (!ev) chk("R9", rel_dat[l*DW +: DW], 32'd0);
          else if (!experr)
            chk((c == trel + 1) ? "R2" : "R5", rel_dat[l*DW +: DW],
                {8'(l), 24'(c - trel - 1)});
        end
      end
      restart = (c == 0);
      mf_tick = (c >= 1) && (c >= tph) && (((c - tph) % MF) == 0);
      rel_ofs = OFS_W'(ofs);
      for (int l = 0; l < NL; l++) begin
        ln_vld[l]  = 1'b0;
        ln_algn[l] = 1'b0;
        ln_dat[l*DW +: DW] = 32'h0;
        if (c >= 1) begin
          if (c >= st[l]) begin
            ln_vld[l] = 1'b1;
            ln_dat[l*DW +: DW] = {8'(l), 24'(c - st[l])};
          end else if (c >= st[l] - NALGN) begin
            ln_vld[l]  = 1'b1;
            ln_algn[l] = 1'b1;
            ln_dat[l*DW +: DW] = 32'h000000BC;
          end else if (l == 0 && c >= st[l] - NALGN - j0) begin
            ln_vld[l] = 1'b1;
            ln_dat[l*DW +: DW] = 32'hDEAD0000 | 32'(c);
          end
        end
      end
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; restart = 1'b0; mf_tick = 1'b0; rel_ofs = '0;
    ln_vld = '0; ln_algn = '0; ln_dat = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", {31'd0, rel_vld}, 32'd0);
    chk("R1", {31'd0, dskw_err}, 32'd0);
    chk("R1", rel_dat[31:0] | rel_dat[63:32] | rel_dat[95:64] | rel_dat[127:96], 32'd0);
  endtask

  // offset 0, junk on lane 0 ahead of alignment
  task automatic t_ofs_zero();  run_scn(10, 12, 11, 14, 3, 0, 15, 40, "R3"); endtask
  // offset 3, earliest lane held 7 cycles: limit without error
  task automatic t_ofs_edge();  run_scn(10, 13, 11, 12, 0, 3, 14, 40, "R4"); endtask
  // offset 4, earliest lane held 8 cycles: overflow
  task automatic t_ofs_over();  run_scn(10, 13, 11, 12, 0, 4, 14, 40, "R4"); endtask
  // boundary before the last lane starts is ignored
  task automatic t_early_tick(); run_scn(15, 20, 16, 18, 2, 0, 5, 48, "R6"); endtask
  // badly placed release far from arrival, error held for many cycles
  task automatic t_far_release(); run_scn(5, 6, 7, 5, 0, 20, 8, 44, "R7"); endtask

  initial begin
    t_reset();
    t_ofs_zero();
    t_ofs_edge();
    t_ofs_over();
    t_early_tick();
    t_far_release();
    t_ofs_zero();
    finish_run();
  end

endmodule